// File: doc/BRIEF.md
# Multi-Channel FIFO Word Window

This block gives a 32-bit bus requester word-wide access to the receive and transmit byte FIFOs of an eight-channel serial controller. Each channel has its own word window address. A read at that address takes up to four bytes from the channel's receive FIFO and packs them into one word. A write at that address splits the word into bytes and pushes them into the channel's transmit FIFO. A 256-byte receive FIFO therefore empties in 64 bus reads, where the byte-wide holding register would need 256.

The requester raises `req_valid` and holds the request stable until `req_ready` pulses. While the block owns the request it moves one byte per cycle through the addressed channel's byte interface. When it completes, it presents the read word and the status flags for exactly the cycle in which `req_ready` is high. The receive FIFOs are show-ahead: `rx_data` already carries the head byte, and a pop advances it. The FIFOs themselves and the byte-wide holding registers are not part of this block.

Top module: `fifo_win_top`

## Requirements
- R1: The window for channel n (0..7) sits at 13-bit address 0x100 + n*0x400 (0x0100, 0x0500 … 0x1D00). Address bits 12:10 select the channel and bits 9:0 must equal 0x100.
- R2: A read packs receive bytes little-endian. The oldest byte goes to bits 7:0, the next to 15:8, and so on, with at most four pops per read.
- R3: A write pushes bits 7:0 of the word first, then 15:8, 23:16 and 31:24, on `tx_data` into the addressed channel.
- R4: When a read finds the receive FIFO empty before four bytes have been taken, it pops only the bytes present, returns zero in the missing upper lanes and raises `rsp_short`. It never pops an empty FIFO.
- R5: When a write finds the transmit FIFO full, it pushes only the bytes that fit and raises `rsp_ovf`. It never pushes into a full FIFO.
- R6: Any address that is not a window (including holding-register addresses such as 0x0000 and misaligned ones such as 0x0104) completes with `rsp_err` high, `rsp_rdata` zero, the short and overflow flags low, and no pop or push.
- R7: `req_ready` is a single-cycle pulse, and the response outputs are valid while it is high. The latency counted in clock edges from the first edge that sees `req_valid` to the edge after which `req_ready` is high is:
  - 5 for a full four-byte transfer;
  - k+2 for a transfer that stops after k bytes;
  - 1 for an error.
- R8: While reset is held low, `req_ready`, `rx_pop` and `tx_push` are all low.
- R9: Only the addressed channel's FIFO is touched. At most one pop and at most one push happen per cycle, and they never happen together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present; held until req_ready |
| req_ready | output | 1 | One-cycle completion pulse |
| req_write | input | 1 | 1 = word write, 0 = word read |
| req_addr | input | 13 | Byte address in the channel region |
| req_wdata | input | 32 | Write word |
| rsp_rdata | output | 32 | Packed read word |
| rsp_err | output | 1 | Address not a window |
| rsp_short | output | 1 | Read found fewer than four bytes |
| rsp_ovf | output | 1 | Write did not fit entirely |
| rx_empty | input | 8 | Per-channel receive FIFO empty |
| rx_data | input | 64 | Per-channel receive head byte, channel n in bits 8n+7:8n |
| rx_pop | output | 8 | Per-channel receive pop strobe |
| tx_full | input | 8 | Per-channel transmit FIFO full |
| tx_data | output | 8 | Byte being pushed |
| tx_push | output | 8 | Per-channel transmit push strobe |

## Verification
A wrong byte index or a latched channel that has gone astray shows up at once as swapped or misplaced lanes in `rsp_rdata`, or as strobes on a neighbouring channel's `rx_pop`/`tx_push`, within the same transaction. A sequencer that stops early or late shows up as a changed `req_ready` latency and as pop or push counts that differ from the bytes available. Because those counts carry over into the FIFO state, a second access to the same channel shows the damage on the next word read as well.

// File: rtl/fifo_win_pkg.sv
package fifo_win_pkg;
    localparam int NUM_CH      = 8;
    localparam int CH_W        = $clog2(NUM_CH);
    localparam int BYTES       = 4;
    localparam int IDX_W       = $clog2(BYTES);
    localparam int WORD_W      = BYTES * 8;
    localparam int STRIDE_LOG2 = 10;
    localparam int ADDR_W      = STRIDE_LOG2 + CH_W;
    localparam logic [STRIDE_LOG2-1:0] WIN_OFS = STRIDE_LOG2'(12'h100);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } win_st_e;

    typedef struct packed {
        win_st_e           st;
        logic              wr;
        logic [CH_W-1:0]   ch;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] rdata;
        logic              err;
        logic              short_f;
        logic              ovf;
    } win_regs_t;
endpackage

// File: rtl/fifo_win_dec.sv
module fifo_win_dec
    import fifo_win_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [CH_W-1:0]   ch
);
    // Low bits pick the offset inside a channel stride, high bits the channel.
    assign hit = (addr[STRIDE_LOG2-1:0] == WIN_OFS);
    assign ch  = addr[ADDR_W-1:STRIDE_LOG2];
endmodule

// File: rtl/fifo_win_sel.sv
module fifo_win_sel
    import fifo_win_pkg::*;
(
    input  logic [CH_W-1:0]        ch,
    input  logic [IDX_W-1:0]       idx,
    input  logic [NUM_CH*8-1:0]    rx_data,
    input  logic [NUM_CH-1:0]      rx_empty,
    input  logic [NUM_CH-1:0]      tx_full,
    input  logic [WORD_W-1:0]      wdata,
    output logic [7:0]             rx_byte,
    output logic [7:0]             tx_byte,
    output logic                   empty_sel,
    output logic                   full_sel
);
    assign rx_byte   = rx_data[{ch, 3'b000} +: 8];
    assign tx_byte   = wdata[{idx, 3'b000} +: 8];
    assign empty_sel = rx_empty[ch];
    assign full_sel  = tx_full[ch];
endmodule

// File: rtl/fifo_win_top.sv
module fifo_win_top
    import fifo_win_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [WORD_W-1:0]     req_wdata,
    output logic [WORD_W-1:0]     rsp_rdata,
    output logic                  rsp_err,
    output logic                  rsp_short,
    output logic                  rsp_ovf,
    input  logic [NUM_CH-1:0]     rx_empty,
    input  logic [NUM_CH*8-1:0]   rx_data,
    output logic [NUM_CH-1:0]     rx_pop,
    input  logic [NUM_CH-1:0]     tx_full,
    output logic [7:0]            tx_data,
    output logic [NUM_CH-1:0]     tx_push
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTES - 1);

    win_regs_t q, d;

    logic            dec_hit;
    logic [CH_W-1:0] dec_ch;
    logic [7:0]      rx_byte;
    logic [7:0]      tx_byte;
    logic            empty_sel;
    logic            full_sel;

    fifo_win_dec u_dec (
        .addr (req_addr),
        .hit  (dec_hit),
        .ch   (dec_ch)
    );

    fifo_win_sel u_sel (
        .ch        (q.ch),
        .idx       (q.idx),
        .rx_data   (rx_data),
        .rx_empty  (rx_empty),
        .tx_full   (tx_full),
        .wdata     (q.wdata),
        .rx_byte   (rx_byte),
        .tx_byte   (tx_byte),
        .empty_sel (empty_sel),
        .full_sel  (full_sel)
    );

    always_comb begin
        d       = q;
        rx_pop  = '0;
        tx_push = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.wr      = req_write;
                    d.ch      = dec_ch;
                    d.idx     = '0;
                    d.wdata   = req_wdata;
                    d.rdata   = '0;
                    d.err     = !dec_hit;
                    d.short_f = 1'b0;
                    d.ovf     = 1'b0;
                    d.st      = dec_hit ? ST_XFER : ST_DONE;
                end
            end
            ST_XFER: begin
                if (!q.wr) begin
                    if (!empty_sel) begin
                        rx_pop[q.ch]                     = 1'b1;
                        d.rdata[{q.idx, 3'b000} +: 8]    = rx_byte;
                        if (q.idx == LAST_IDX) d.st = ST_DONE;
                        else                   d.idx = q.idx + 1'b1;
                    end else begin
                        d.short_f = 1'b1;
                        d.st      = ST_DONE;
                    end
                end else begin
                    if (!full_sel) begin
                        tx_push[q.ch] = 1'b1;
                        if (q.idx == LAST_IDX) d.st = ST_DONE;
                        else                   d.idx = q.idx + 1'b1;
                    end else begin
                        d.ovf = 1'b1;
                        d.st  = ST_DONE;
                    end
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_DONE);
    assign rsp_rdata = q.rdata;
    assign rsp_err   = q.err;
    assign rsp_short = q.short_f;
    assign rsp_ovf   = q.ovf;
    assign tx_data   = tx_byte;
endmodule

// File: rtl/fifo_win_chk.sv
module fifo_win_chk
    import fifo_win_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                req_ready,
    input logic [WORD_W-1:0]   rsp_rdata,
    input logic                rsp_err,
    input logic                rsp_short,
    input logic                rsp_ovf,
    input logic [NUM_CH-1:0]   rx_empty,
    input logic [NUM_CH-1:0]   rx_pop,
    input logic [NUM_CH-1:0]   tx_full,
    input logic [NUM_CH-1:0]   tx_push
);
    localparam int CNT_W = $clog2(BYTES + 2) + 1;
    logic [CNT_W-1:0] moves_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         moves_q <= '0;
        else if (req_ready) moves_q <= '0;
        else                moves_q <= moves_q + CNT_W'($countones(rx_pop))
                                               + CNT_W'($countones(tx_push));
    end

    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (rx_pop == '0 && tx_push == '0); // R8
        end
    end

    AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_pop)); // R9
    AST_PUSH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_push)); // R9
    AST_NO_MIXED_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        !((|rx_pop) && (|tx_push))); // R9
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop & rx_empty) == '0); // R4
    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push & tx_full) == '0); // R5
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready); // R7
    AST_MAX_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
        moves_q <= CNT_W'(BYTES)); // R2
    AST_QUIET_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (rx_pop == '0 && tx_push == '0)); // R7
    AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && rsp_err) |-> (rsp_rdata == '0 && !rsp_short && !rsp_ovf)); // R6
endmodule

bind fifo_win_top fifo_win_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .rsp_short (rsp_short),
    .rsp_ovf   (rsp_ovf),
    .rx_empty  (rx_empty),
    .rx_pop    (rx_pop),
    .tx_full   (tx_full),
    .tx_push   (tx_push)
);

// File: tb/sim_fifo_win_top.sv
`timescale 1ns/1ps
module sim_fifo_win_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_err, rsp_short, rsp_ovf;
    logic [7:0]  rx_empty;
    logic [63:0] rx_data;
    logic [7:0]  rx_pop;
    logic [7:0]  tx_full;
    logic [7:0]  tx_data;
    logic [7:0]  tx_push;

    always #4 clk = ~clk; // 125 MHz

    fifo_win_top u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .rsp_short(rsp_short),
        .rsp_ovf(rsp_ovf), .rx_empty(rx_empty), .rx_data(rx_data),
        .rx_pop(rx_pop), .tx_full(tx_full), .tx_data(tx_data), .tx_push(tx_push)
    );

    // Behavioural FIFO model: channel c head byte = c*16 + head + 1
    logic [7:0] rx_cnt  [8];
    logic [7:0] rx_head [8];
    logic [7:0] tx_space[8];
    logic [7:0] tx_log  [8];
    int         tx_n = 0;
    int         rx_n = 0;
    int         other_moves = 0;
    logic [2:0] cur_ch = '0;

    always_comb begin
        for (int c = 0; c < 8; c++) begin
            rx_data[c*8 +: 8] = 8'(c * 16) + rx_head[c] + 8'd1;
            rx_empty[c]       = (rx_cnt[c] == 8'd0);
            tx_full[c]        = (tx_space[c] == 8'd0);
        end
    end

    always @(posedge clk) begin
        for (int c = 0; c < 8; c++) begin
            if (rx_pop[c]) begin
                if (rx_cnt[c] != 0) begin
                    rx_cnt[c]  = rx_cnt[c] - 8'd1;
                    rx_head[c] = rx_head[c] + 8'd1;
                end
                if (3'(c) != cur_ch) other_moves++;
                else rx_n++;
            end
            if (tx_push[c]) begin
                if (tx_space[c] != 0) tx_space[c] = tx_space[c] - 8'd1;
                if (3'(c) != cur_ch) other_moves++;
                else begin
                    if (tx_n < 8) tx_log[tx_n] = tx_data;
                    tx_n++;
                end
            end
        end
    end

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic setup(input logic [2:0] ch, input int fill, input int space);
        @(negedge clk);
        for (int c = 0; c < 8; c++) begin
            rx_cnt[c]   = 8'd0;
            rx_head[c]  = 8'd0;
            tx_space[c] = 8'd0;
        end
        rx_cnt[ch]   = 8'(fill);
        tx_space[ch] = 8'(space);
        cur_ch = ch;
        tx_n = 0; rx_n = 0; other_moves = 0;
    endtask

    task automatic txn(input logic wr, input logic [12:0] addr, input logic [31:0] wd,
                       output logic [31:0] rd, output logic er, output logic sh,
                       output logic ov, output int lat);
        @(negedge clk);
        rx_n = 0; tx_n = 0; other_moves = 0;
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        lat = 0;
        rd = '0; er = 1'b0; sh = 1'b0; ov = 1'b0;
        for (int k = 0; k < 50; k++) begin
            @(posedge clk); #1;
            lat++;
            if (req_ready) begin
                rd = rsp_rdata; er = rsp_err; sh = rsp_short; ov = rsp_ovf;
                break;
            end
        end
        req_valid = 1'b0;
        if (!req_ready) check(1'b0, "R7", "no ready", 32'(lat), 32'd50);
        @(posedge clk); #1;
        check(!req_ready, "R7", "ready pulse width", {31'd0, req_ready}, 32'd0);
    endtask

    typedef struct packed {
        logic        wr;
        logic [12:0] addr;
        logic [31:0] wdata;
        logic [2:0]  fill;
        logic [2:0]  space;
        logic        err;
        logic        sh;
        logic        ov;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 13'h0100, 32'h0,         3'd4, 3'd0, 1'b0, 1'b0, 1'b0}, // R1 R2 ch0 full
        '{1'b0, 13'h1D00, 32'h0,         3'd5, 3'd0, 1'b0, 1'b0, 1'b0}, // R1 R2 ch7 extra byte
        '{1'b0, 13'h0D00, 32'h0,         3'd2, 3'd0, 1'b0, 1'b1, 1'b0}, // R4 short
        '{1'b0, 13'h0900, 32'h0,         3'd0, 3'd0, 1'b0, 1'b1, 1'b0}, // R4 empty
        '{1'b1, 13'h0500, 32'hA1B2C3D4,  3'd0, 3'd7, 1'b0, 1'b0, 1'b0}, // R3 write
        '{1'b1, 13'h1900, 32'h11223344,  3'd0, 3'd3, 1'b0, 1'b0, 1'b1}, // R5 partial
        '{1'b1, 13'h1100, 32'hDEADBEEF,  3'd0, 3'd0, 1'b0, 1'b0, 1'b1}, // R5 full
        '{1'b0, 13'h0000, 32'h0,         3'd4, 3'd0, 1'b1, 1'b0, 1'b0}, // R6 holding reg
        '{1'b1, 13'h0104, 32'h55AA55AA,  3'd0, 3'd7, 1'b1, 1'b0, 1'b0}, // R6 misaligned
        '{1'b0, 13'h1F00, 32'h0,         3'd6, 3'd0, 1'b1, 1'b0, 1'b0}  // R6 reserved offset
    };

    initial begin
        logic [31:0] rd, exp_rd;
        logic er, sh, ov;
        int lat, n, exp_lat;
        logic [2:0] ch;

        for (int c = 0; c < 8; c++) begin
            rx_cnt[c] = 0; rx_head[c] = 0; tx_space[c] = 0; tx_log[c] = 0;
        end

        // R8: reset state
        repeat (3) @(posedge clk);
        #1;
        check(!req_ready, "R8", "ready in reset", {31'd0, req_ready}, 32'd0);
        check(rx_pop == 0 && tx_push == 0, "R8", "strobes in reset",
              {16'd0, rx_pop, tx_push}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            ch = VEC[v].addr[12:10];
            setup(ch, int'(VEC[v].fill), int'(VEC[v].space));
            txn(VEC[v].wr, VEC[v].addr, VEC[v].wdata, rd, er, sh, ov, lat);
            if (VEC[v].err) n = 0;
            else if (VEC[v].wr) n = (VEC[v].space > 3'd4) ? 4 : int'(VEC[v].space);
            else n = (VEC[v].fill > 3'd4) ? 4 : int'(VEC[v].fill);
            exp_rd = '0;
            if (!VEC[v].wr)
                for (int i = 0; i < n; i++) exp_rd[i*8 +: 8] = 8'(ch * 16 + i + 1);
            exp_lat = VEC[v].err ? 1 : (n == 4 ? 5 : n + 2);
            check(er == VEC[v].err, "R6", "err flag", {31'd0, er}, {31'd0, VEC[v].err});
            check(sh == VEC[v].sh, "R4", "short flag", {31'd0, sh}, {31'd0, VEC[v].sh});
            check(ov == VEC[v].ov, "R5", "ovf flag", {31'd0, ov}, {31'd0, VEC[v].ov});
            check(rd == exp_rd, "R2", "read word", rd, exp_rd);
            check(lat == exp_lat, "R7", "latency", 32'(lat), 32'(exp_lat));
            check(other_moves == 0, "R9", "foreign channel moves", 32'(other_moves), 32'd0);
            if (VEC[v].wr) begin
                check(tx_n == n, "R5", "push count", 32'(tx_n), 32'(n));
                for (int i = 0; i < n; i++)
                    check(tx_log[i] == VEC[v].wdata[i*8 +: 8], "R3", "pushed byte order",
                          {24'd0, tx_log[i]}, {24'd0, VEC[v].wdata[i*8 +: 8]});
                check(rx_n == 0, "R6", "pops on write", 32'(rx_n), 32'd0);
            end else begin
                check(rx_n == n, "R4", "pop count", 32'(rx_n), 32'(n));
                check(tx_n == 0, "R6", "pushes on read", 32'(tx_n), 32'd0);
            end
        end

        // R2/R4: back-to-back reads on channel 5 continue from the FIFO head
        setup(3'd5, 6, 0);
        txn(1'b0, 13'h1500, 32'h0, rd, er, sh, ov, lat);
        check(rd == 32'h54535251 && !sh, "R2", "first word ch5", rd, 32'h54535251);
        txn(1'b0, 13'h1500, 32'h0, rd, er, sh, ov, lat);
        check(rd == 32'h00005655, "R4", "second word ch5", rd, 32'h00005655);
        check(sh, "R4", "second short", {31'd0, sh}, 32'd1);
        check(lat == 4, "R7", "short latency", 32'(lat), 32'd4);

        // R1: address 0x0500 reaches channel 1 only, not channel 0
        setup(3'd1, 4, 0);
        txn(1'b0, 13'h0500, 32'h0, rd, er, sh, ov, lat);
        check(rd == 32'h14131211, "R1", "ch1 window", rd, 32'h14131211);
        check(other_moves == 0 && rx_n == 4, "R9", "ch1 pops only", 32'(rx_n), 32'd4);

        // R6: error leaves FIFO level unchanged, visible through next valid read
        setup(3'd0, 4, 0);
        txn(1'b0, 13'h0000, 32'h0, rd, er, sh, ov, lat);
        txn(1'b0, 13'h0100, 32'h0, rd, er, sh, ov, lat);
        check(rd == 32'h04030201 && !er, "R6", "FIFO intact after error", rd, 32'h04030201);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule